// File: doc/BRIEF.md
# Split/Double-Buffered Endpoint Packet Buffer

This block is the byte-wide packet store behind one USB device endpoint. Firmware touches it through one access address: each read of that address takes one byte out and each write puts one byte in. The serial-interface engine on the far side moves whole packets. It writes or reads bytes, commits a finished packet and releases a consumed one. Firmware does the same from its side with commit and release strobes.

The storage can run in two layouts, chosen at run time. Unsplit, it is one shared buffer. Either side may load it and either side may drain it. Split, the lower half carries IN traffic (firmware writes, serial side reads) and the upper half carries OUT traffic (serial side writes, firmware reads). The same access address serves both halves: a read drains OUT and a write fills IN. Each buffer may be single slot or ping-pong with two slots. Two slots hold two complete packets, and each slot has half the capacity. Total storage is `BASE_BYTES << EP_ID` for endpoints 1 to 3. Endpoint 0 gets a single `BASE_BYTES` buffer, and its split and double controls are ignored.

Top module: `ep_fifo_top`

## Requirements
- R1: After reset both read-data outputs are 0x00, no packet is ready, no buffer is full, no overrun is flagged, and both empty flags are set. Flag bit 0 belongs to the IN/shared buffer and bit 1 to the OUT half.
- R2: Unsplit and single slot, one packet may hold the whole storage (`BASE_BYTES << EP_ID` bytes). A further byte written before release is dropped.
- R3: In ping-pong mode each slot holds half of its buffer and two committed packets coexist. The full flag rises once every slot holds a committed packet: one packet in single mode, two in ping-pong mode.
- R4: In ping-pong mode packets are read back in commit order. The writer changes slot only on commit and the reader only on release.
- R5: With split set, a read at the access address returns OUT bytes written by the serial side, and a write there feeds IN bytes that the serial side reads. Unsplit, both sides share buffer 0, and the bit-1 flags stay idle: not ready and no overrun.
- R6: With split set, each half holds half the storage. A half in ping-pong mode has slots of a quarter of the storage, and the IN and OUT halves choose ping-pong independently.
- R7: Only the address `ACC_BASE + EP_ID` (0x21 for endpoint 1) reaches the buffer. Reads or writes at any other address leave the contents and the read-data output unchanged.
- R8: A read with no unread byte in the current packet returns 0x00 and does not move the read position.
- R9: A write that cannot be stored sets the overrun flag of that buffer. The flag stays set until the configuration changes or reset.
- R10: Any change of the effective split or ping-pong setting clears every slot, pointer, packet count and overrun flag of the endpoint.
- R11: Unsplit, when firmware and the serial side write in the same cycle, only the firmware byte is stored. The serial byte is dropped without raising overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_i | input | 1 | Split storage into IN and OUT halves |
| in_dbl_i | input | 1 | Ping-pong for IN half, or for whole buffer when unsplit |
| out_dbl_i | input | 1 | Ping-pong for OUT half (split only) |
| cpu_addr_i | input | 8 | Firmware access address |
| cpu_wr_i | input | 1 | Firmware byte write |
| cpu_wdata_i | input | 8 | Firmware write byte |
| cpu_rd_i | input | 1 | Firmware byte read |
| cpu_rdata_o | output | 8 | Last byte read by firmware |
| cpu_in_commit_i | input | 1 | Firmware marks IN/shared packet complete |
| cpu_out_release_i | input | 1 | Firmware frees consumed OUT/shared packet |
| sie_wr_i | input | 1 | Serial side byte write |
| sie_wdata_i | input | 8 | Serial side write byte |
| sie_out_commit_i | input | 1 | Serial side marks OUT/shared packet complete |
| sie_rd_i | input | 1 | Serial side byte read |
| sie_rdata_o | output | 8 | Last byte read by serial side |
| sie_in_release_i | input | 1 | Serial side frees consumed IN/shared packet |
| pkt_rdy_o | output | 2 | At least one committed packet per buffer |
| full_o | output | 2 | All slots of a buffer hold committed packets |
| empty_o | output | 2 | No unread byte available to the reader |
| overrun_o | output | 2 | Sticky dropped-write flag per buffer |

## Verification
The assertions watch several rules on every cycle. A full buffer always reports a ready packet. The overrun flag never drops except on a flush, and a flush leaves no packet, fullness or overrun behind. A firmware read of an empty buffer yields 0x00. Off-address reads never alter the read data, and the OUT flags stay idle while unsplit. Only the bench scenarios can show the rest: the capacity of each layout, the byte values and their order across ping-pong slots, the mapping of one address onto two halves, and the write collision rule. The bench shows these by sweeping every effective configuration and comparing against arithmetic byte patterns.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
  typedef struct packed {
    logic split;
    logic dbl_in;
    logic dbl_out;
  } ep_cfg_t;

  function automatic int unsigned ep_bytes(int unsigned ep, int unsigned base);
    return (ep == 0) ? base : (base << ep);
  endfunction
endpackage

// File: rtl/ep_buf_ram.sv
module ep_buf_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic [1:0]          we_i,
  input  logic [1:0][AW-1:0]  waddr_i,
  input  logic [1:0][7:0]     wdata_i,
  input  logic [1:0][AW-1:0]  raddr_i,
  output logic [1:0][7:0]     rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < 2; p++) begin
      if (we_i[p]) mem[waddr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rdata_o[p] = mem[raddr_i[p]];
  end
endmodule

// File: rtl/ep_fifo_chan.sv
module ep_fifo_chan #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          dbl_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW:0]   cap_i,
  input  logic          wr_i,
  input  logic          commit_i,
  input  logic          rd_i,
  input  logic          release_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          rd_ok_o,
  output logic          pkt_rdy_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          overrun_o
);
  logic [AW:0]        wr_cnt_q, rd_ptr_q;
  logic [1:0][AW:0]   len_q;
  logic               wr_slot_q, rd_slot_q;
  logic [1:0]         pkts_q, slots;
  logic               overrun_q;
  logic               can_wr, can_rd, wr_ok, do_commit, do_rel;
  logic [AW:0]        wr_cnt_nx;

  assign slots     = dbl_i ? 2'd2 : 2'd1;
  assign can_wr    = (pkts_q < slots) && (wr_cnt_q < cap_i);
  assign can_rd    = (pkts_q != 2'd0) && (rd_ptr_q < len_q[rd_slot_q]);
  assign wr_ok     = wr_i & can_wr & ~flush_i;
  assign rd_ok_o   = rd_i & can_rd & ~flush_i;
  assign do_commit = commit_i & (pkts_q < slots) & ~flush_i;
  assign do_rel    = release_i & (pkts_q != 2'd0) & ~flush_i;
  assign wr_cnt_nx = wr_cnt_q + {{AW{1'b0}}, wr_ok};

  assign we_o    = wr_ok;
  assign waddr_o = base_i + (wr_slot_q ? cap_i[AW-1:0] : '0) + wr_cnt_q[AW-1:0];
  assign raddr_o = base_i + (rd_slot_q ? cap_i[AW-1:0] : '0) + rd_ptr_q[AW-1:0];

  assign pkt_rdy_o = pkts_q != 2'd0;
  assign full_o    = pkts_q == slots;
  assign empty_o   = ~can_rd;
  assign overrun_o = overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q  <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      wr_slot_q <= 1'b0;
      rd_slot_q <= 1'b0;
      pkts_q    <= '0;
      overrun_q <= 1'b0;
    end else if (flush_i) begin
      wr_cnt_q  <= '0;
      rd_ptr_q  <= '0;
      len_q     <= '0;
      wr_slot_q <= 1'b0;
      rd_slot_q <= 1'b0;
      pkts_q    <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (wr_ok) wr_cnt_q <= wr_cnt_nx;
      if (wr_i && !can_wr) overrun_q <= 1'b1;
      if (do_commit) begin
        len_q[wr_slot_q] <= wr_cnt_nx;
        wr_cnt_q         <= '0;
        if (dbl_i) wr_slot_q <= ~wr_slot_q;
      end
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_rel) begin
        rd_ptr_q <= '0;
        if (dbl_i) rd_slot_q <= ~rd_slot_q;
      end
      pkts_q <= pkts_q + {1'b0, do_commit} - {1'b0, do_rel};
    end
  end
endmodule

// File: rtl/ep_fifo_top.sv
module ep_fifo_top
  import ep_fifo_pkg::*;
#(
  parameter int         EP_ID      = 1,
  parameter int         BASE_BYTES = 64,
  parameter logic [7:0] ACC_BASE   = 8'h20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       split_i,
  input  logic       in_dbl_i,
  input  logic       out_dbl_i,
  input  logic [7:0] cpu_addr_i,
  input  logic       cpu_wr_i,
  input  logic [7:0] cpu_wdata_i,
  input  logic       cpu_rd_i,
  output logic [7:0] cpu_rdata_o,
  input  logic       cpu_in_commit_i,
  input  logic       cpu_out_release_i,
  input  logic       sie_wr_i,
  input  logic [7:0] sie_wdata_i,
  input  logic       sie_out_commit_i,
  input  logic       sie_rd_i,
  output logic [7:0] sie_rdata_o,
  input  logic       sie_in_release_i,
  output logic [1:0] pkt_rdy_o,
  output logic [1:0] full_o,
  output logic [1:0] empty_o,
  output logic [1:0] overrun_o
);
  localparam int         TOTAL   = ep_bytes(EP_ID, BASE_BYTES);
  localparam int         HALF    = TOTAL / 2;
  localparam int         AW      = $clog2(TOTAL);
  localparam logic [AW:0] TOTAL_W = (AW + 1)'(TOTAL);
  localparam logic [AW:0] HALF_W  = (AW + 1)'(HALF);
  localparam logic [7:0] MY_ADDR = ACC_BASE + 8'(EP_ID);

  ep_cfg_t cfg_d, cfg_q;
  logic    flush, split_eff, cpu_rd_hit, cpu_wr_hit, sie_rd_take;

  // endpoint 0 is fixed single-slot, unsplit
  if (EP_ID == 0) begin : g_ep0
    assign cfg_d = '0;
  end else begin : g_epn
    assign cfg_d = {split_i, in_dbl_i, split_i & out_dbl_i};
  end

  assign split_eff  = cfg_d.split;
  assign flush      = cfg_d != cfg_q;
  assign cpu_rd_hit = cpu_rd_i & (cpu_addr_i == MY_ADDR);
  assign cpu_wr_hit = cpu_wr_i & (cpu_addr_i == MY_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  logic [1:0]         ch_wr, ch_commit, ch_rd, ch_rel, ch_dbl;
  logic [1:0][AW-1:0] ch_base, ch_waddr, ch_raddr;
  logic [1:0][AW:0]   ch_cap;
  logic [1:0]         ch_we, ch_rd_ok;
  logic [1:0][7:0]    ch_wdata, ch_rdata;

  // buffer 0: IN half or whole shared buffer; buffer 1: OUT half
  assign ch_wr[0]     = cpu_wr_hit | (~split_eff & sie_wr_i);
  assign ch_wdata[0]  = cpu_wr_hit ? cpu_wdata_i : sie_wdata_i;
  assign ch_commit[0] = cpu_in_commit_i | (~split_eff & sie_out_commit_i);
  assign ch_rd[0]     = sie_rd_i | (~split_eff & cpu_rd_hit);
  assign ch_rel[0]    = sie_in_release_i | (~split_eff & cpu_out_release_i);
  assign ch_dbl[0]    = cfg_d.dbl_in;
  assign ch_base[0]   = '0;
  assign ch_cap[0]    = (split_eff ? HALF_W : TOTAL_W) >> cfg_d.dbl_in;

  assign ch_wr[1]     = split_eff & sie_wr_i;
  assign ch_wdata[1]  = sie_wdata_i;
  assign ch_commit[1] = split_eff & sie_out_commit_i;
  assign ch_rd[1]     = split_eff & cpu_rd_hit;
  assign ch_rel[1]    = split_eff & cpu_out_release_i;
  assign ch_dbl[1]    = cfg_d.dbl_out;
  assign ch_base[1]   = AW'(HALF);
  assign ch_cap[1]    = HALF_W >> cfg_d.dbl_out;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    ep_fifo_chan #(.AW(AW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush),
      .dbl_i     (ch_dbl[c]),
      .base_i    (ch_base[c]),
      .cap_i     (ch_cap[c]),
      .wr_i      (ch_wr[c]),
      .commit_i  (ch_commit[c]),
      .rd_i      (ch_rd[c]),
      .release_i (ch_rel[c]),
      .we_o      (ch_we[c]),
      .waddr_o   (ch_waddr[c]),
      .raddr_o   (ch_raddr[c]),
      .rd_ok_o   (ch_rd_ok[c]),
      .pkt_rdy_o (pkt_rdy_o[c]),
      .full_o    (full_o[c]),
      .empty_o   (empty_o[c]),
      .overrun_o (overrun_o[c])
    );
  end

  ep_buf_ram #(.DEPTH(TOTAL), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ch_we),
    .waddr_i (ch_waddr),
    .wdata_i (ch_wdata),
    .raddr_i (ch_raddr),
    .rdata_o (ch_rdata)
  );

  // unsplit: firmware wins a same-cycle read of the shared buffer
  assign sie_rd_take = sie_rd_i & (split_eff | ~cpu_rd_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rdata_o <= '0;
      sie_rdata_o <= '0;
    end else begin
      if (cpu_rd_hit) begin
        if (split_eff) cpu_rdata_o <= ch_rd_ok[1] ? ch_rdata[1] : 8'h00;
        else           cpu_rdata_o <= ch_rd_ok[0] ? ch_rdata[0] : 8'h00;
      end
      if (sie_rd_take) sie_rdata_o <= ch_rd_ok[0] ? ch_rdata[0] : 8'h00;
    end
  end
endmodule

// File: rtl/ep_fifo_chk.sv
module ep_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       flush_i,
  input logic       split_eff_i,
  input logic       cpu_rd_i,
  input logic       cpu_rd_hit_i,
  input logic [7:0] cpu_rdata_i,
  input logic [1:0] pkt_rdy_i,
  input logic [1:0] full_i,
  input logic [1:0] empty_i,
  input logic [1:0] overrun_i
);
  p_full_has_pkt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i & ~pkt_rdy_i) == 2'b00);

  p_out_idle_unsplit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_eff_i && $past(!split_eff_i)) |-> (!pkt_rdy_i[1] && !overrun_i[1]));

  p_miss_holds_rdata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !cpu_rd_hit_i) |=> $stable(cpu_rdata_i));

  p_empty_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_hit_i && !flush_i && (split_eff_i ? empty_i[1] : empty_i[0]))
      |=> (cpu_rdata_i == 8'h00));

  p_overrun_sticky0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i[0] && !flush_i) |=> overrun_i[0]);

  p_overrun_sticky1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i[1] && !flush_i) |=> overrun_i[1]);

  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pkt_rdy_i == 2'b00 && full_i == 2'b00 && overrun_i == 2'b00
                 && empty_i == 2'b11));
endmodule

bind ep_fifo_top ep_fifo_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush),
  .split_eff_i  (split_eff),
  .cpu_rd_i     (cpu_rd_i),
  .cpu_rd_hit_i (cpu_rd_hit),
  .cpu_rdata_i  (cpu_rdata_o),
  .pkt_rdy_i    (pkt_rdy_o),
  .full_i       (full_o),
  .empty_i      (empty_o),
  .overrun_i    (overrun_o)
);

// File: tb/ep_fifo_top_test.sv
module ep_fifo_top_test;
  localparam int         CLK_NS = 10;
  localparam int         EP     = 1;
  localparam int         BASE   = 8;
  localparam int         TOTAL  = BASE << EP;
  localparam int         HALF   = TOTAL / 2;
  localparam logic [7:0] ADDR   = 8'h20 + 8'(EP);

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       split_i = 0, in_dbl_i = 0, out_dbl_i = 0;
  logic [7:0] cpu_addr_i = 0, cpu_wdata_i = 0, sie_wdata_i = 0;
  logic       cpu_wr_i = 0, cpu_rd_i = 0, cpu_in_commit_i = 0, cpu_out_release_i = 0;
  logic       sie_wr_i = 0, sie_rd_i = 0, sie_out_commit_i = 0, sie_in_release_i = 0;
  logic [7:0] cpu_rdata_o, sie_rdata_o;
  logic [1:0] pkt_rdy_o, full_o, empty_o, overrun_o;

  int n_chk = 0, n_fail = 0;

  ep_fifo_top #(.EP_ID(EP), .BASE_BYTES(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .split_i(split_i), .in_dbl_i(in_dbl_i),
    .out_dbl_i(out_dbl_i), .cpu_addr_i(cpu_addr_i), .cpu_wr_i(cpu_wr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rd_i(cpu_rd_i), .cpu_rdata_o(cpu_rdata_o),
    .cpu_in_commit_i(cpu_in_commit_i), .cpu_out_release_i(cpu_out_release_i),
    .sie_wr_i(sie_wr_i), .sie_wdata_i(sie_wdata_i), .sie_out_commit_i(sie_out_commit_i),
    .sie_rd_i(sie_rd_i), .sie_rdata_o(sie_rdata_o), .sie_in_release_i(sie_in_release_i),
    .pkt_rdy_o(pkt_rdy_o), .full_o(full_o), .empty_o(empty_o), .overrun_o(overrun_o)
  );

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [7:0] pat(int k, int i);
    return {2'b01, 6'(k * 5 + i)};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cpu_write(logic [7:0] a, logic [7:0] d);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_wr_i = 1;
    @(negedge clk); cpu_wr_i = 0;
  endtask
  task automatic cpu_read(logic [7:0] a, output logic [7:0] d);
    cpu_addr_i = a; cpu_rd_i = 1;
    @(negedge clk); cpu_rd_i = 0; d = cpu_rdata_o;
  endtask
  task automatic sie_write(logic [7:0] d);
    sie_wdata_i = d; sie_wr_i = 1;
    @(negedge clk); sie_wr_i = 0;
  endtask
  task automatic sie_read(output logic [7:0] d);
    sie_rd_i = 1;
    @(negedge clk); sie_rd_i = 0; d = sie_rdata_o;
  endtask
  task automatic both_write(logic [7:0] c, logic [7:0] s);
    cpu_addr_i = ADDR; cpu_wdata_i = c; sie_wdata_i = s; cpu_wr_i = 1; sie_wr_i = 1;
    @(negedge clk); cpu_wr_i = 0; sie_wr_i = 0;
  endtask
  task automatic cpu_commit();  cpu_in_commit_i = 1;   @(negedge clk); cpu_in_commit_i = 0;   endtask
  task automatic cpu_release(); cpu_out_release_i = 1; @(negedge clk); cpu_out_release_i = 0; endtask
  task automatic sie_commit();  sie_out_commit_i = 1;  @(negedge clk); sie_out_commit_i = 0;  endtask
  task automatic sie_release(); sie_in_release_i = 1;  @(negedge clk); sie_in_release_i = 0;  endtask
  task automatic set_cfg(logic s, logic i, logic o);
    split_i = s; in_dbl_i = i; out_dbl_i = o;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [2:0] cfgs [6];
    cfgs = '{3'b000, 3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cpu_rdata", cpu_rdata_o, 0);
    chk("R1 sie_rdata", sie_rdata_o, 0);
    chk("R1 pkt_rdy", pkt_rdy_o, 0);
    chk("R1 full", full_o, 0);
    chk("R1 empty", empty_o, 3);
    chk("R1 overrun", overrun_o, 0);

    // sweep over every effective configuration (R2 R3 R5 R6 R8 R9 R10)
    for (int k = 0; k < 6; k++) begin
      logic s, di, dout;
      int cap0, cap1;
      s = cfgs[k][2]; di = cfgs[k][1]; dout = cfgs[k][0];
      set_cfg(s, di, dout);
      chk("R10 flush pkt_rdy", pkt_rdy_o, 0);
      chk("R10 flush overrun", overrun_o, 0);
      cap0 = (s ? HALF : TOTAL) >> di;
      cap1 = HALF >> dout;
      for (int i = 0; i < cap0; i++) cpu_write(ADDR, pat(k, i));
      chk(s ? "R6 in cap no overrun" : "R2 cap no overrun", overrun_o[0], 0);
      cpu_write(ADDR, 8'hEE);
      chk("R9 overrun in", overrun_o[0], 1);
      if (s) begin
        for (int i = 0; i < cap1; i++) sie_write(pat(k + 6, i));
        chk("R6 out cap no overrun", overrun_o[1], 0);
        sie_write(8'hEE);
        chk("R9 overrun out", overrun_o[1], 1);
      end
      cpu_commit();
      chk("R3 pkt_rdy in", pkt_rdy_o[0], 1);
      chk("R3 full in", full_o[0], di ? 0 : 1);
      if (s) begin
        sie_commit();
        chk("R3 full out", full_o[1], dout ? 0 : 1);
      end
      for (int i = 0; i < cap0; i++) begin
        sie_read(d);
        chk(s ? "R5 in data" : "R2 data", d, pat(k, i));
      end
      sie_read(d);
      chk("R8 empty read", d, 0);
      chk("R8 empty flag", empty_o[0], 1);
      if (s) begin
        for (int i = 0; i < cap1; i++) begin
          cpu_read(ADDR, d);
          chk("R5 out data", d, pat(k + 6, i));
        end
        cpu_read(ADDR, d);
        chk("R8 empty read out", d, 0);
      end else begin
        chk("R5 out idle", pkt_rdy_o[1], 0);
      end
      sie_release();
      chk("R3 released", pkt_rdy_o[0], 0);
      chk("R9 sticky", overrun_o[0], 1);
      if (s) cpu_release();
    end

    // R4 ping-pong order, unsplit
    set_cfg(0, 1, 0);
    for (int i = 0; i < 3; i++) cpu_write(ADDR, pat(20, i));
    cpu_commit();
    for (int i = 0; i < 5; i++) sie_write(pat(21, i));
    sie_commit();
    chk("R3 two packets full", full_o[0], 1);
    for (int i = 0; i < 3; i++) begin
      cpu_read(ADDR, d);
      chk("R4 first packet", d, pat(20, i));
    end
    cpu_read(ADDR, d);
    chk("R8 end of packet", d, 0);
    cpu_release();
    chk("R4 one left", full_o[0], 0);
    for (int i = 0; i < 2; i++) cpu_write(ADDR, pat(22, i));
    cpu_commit();
    chk("R4 full again", full_o[0], 1);
    for (int i = 0; i < 5; i++) begin
      sie_read(d);
      chk("R4 second packet", d, pat(21, i));
    end
    sie_release();
    for (int i = 0; i < 2; i++) begin
      sie_read(d);
      chk("R4 third packet", d, pat(22, i));
    end
    sie_release();
    chk("R4 drained", pkt_rdy_o[0], 0);

    // R7 address decode, split
    set_cfg(1, 0, 0);
    cpu_write(8'h20, 8'h11);
    cpu_write(8'h22, 8'h12);
    cpu_write(8'h23, 8'h13);
    cpu_write(ADDR, 8'h5A);
    cpu_commit();
    sie_read(d);
    chk("R7 hit byte", d, 8'h5A);
    sie_read(d);
    chk("R7 misses not stored", d, 0);
    sie_write(8'h33);
    sie_commit();
    cpu_read(8'h22, d);
    chk("R7 miss read holds", d, 0);
    chk("R7 miss read no drain", empty_o[1], 0);
    cpu_read(ADDR, d);
    chk("R7 hit read", d, 8'h33);

    // R11 write collision, unsplit
    set_cfg(0, 0, 0);
    both_write(8'h4C, 8'h7D);
    cpu_commit();
    sie_read(d);
    chk("R11 firmware byte kept", d, 8'h4C);
    sie_read(d);
    chk("R11 serial byte dropped", d, 0);
    chk("R11 no overrun", overrun_o[0], 0);
    sie_release();

    // R10 flush with pending data
    for (int i = 0; i < 4; i++) cpu_write(ADDR, pat(30, i));
    cpu_commit();
    chk("R10 pending", pkt_rdy_o[0], 1);
    set_cfg(1, 0, 0);
    chk("R10 cleared rdy", pkt_rdy_o, 0);
    chk("R10 cleared empty", empty_o, 3);
    set_cfg(0, 0, 0);
    sie_read(d);
    chk("R10 nothing left", d, 0);

    finish_run();
  end
endmodule